// File: doc/BRIEF.md
# Pin Interrupt Detector with Priority Vector

This block watches 32 external input pins and turns their activity into interrupt requests for a processor. Each pin is passed through a two-stage synchronizer. It is then classified, pin by pin, as either a level condition of a chosen polarity, or an edge event on the rising edge, the falling edge or both. The detected condition goes into a status bit. That bit either latches the event until software clears it, or simply tracks the detection cycle by cycle.

Status bits are gated by per-pin enable bits. The OR of the gated bits forms a single registered interrupt request. A registered 5-bit vector names the lowest-numbered pending pin, and a valid flag comes with it. Software reaches the configuration through a plain 16-bit register bus. Pins 0–15 and pins 16–31 each have their own copy of every register.

The bus has no handshake and no back-pressure. Every write strobe is taken at the clock edge where it is high. The read data is a combinational function of the address, so it is valid in the same cycle as the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle it is released, every register reads 0, `irq_o` and `vec_valid_o` are low and `vec_o` is 0.
- R2: Each pin passes through two synchronizing flops. A pin change applied before clock edge n shows in a non-held status bit after edge n+2, and not earlier.
- R3: A type bit of 0 selects level detection. The condition is true while the synchronized pin equals its polarity bit (1 = active high, 0 = active low).
- R4: A type bit of 1 selects edge detection against the previous synchronized sample. The rise bit catches 0→1, the fall bit catches 1→0, both bits set catch both edges, and neither bit set gives no event.
- R5: With its hold bit at 1, a status bit is set by an event and stays set until cleared. With its hold bit at 0, a status bit follows the detection result on every edge.
- R6: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Status bits cannot be set from the bus.
- R7: If a new event and a clear of the same held status bit occur on the same edge, the bit stays set.
- R8: `irq_o` is a register that takes the OR over all pins of status AND enable. It follows the state one cycle later, and stays low while both enable registers are 0.
- R9: If any pin 0–15 is pending, `vec_o` gives the lowest such pin. Otherwise it gives 16 plus the lowest pending bit of pins 16–31. `vec_valid_o` equals `irq_o`, and `vec_o` is 0 when no pin is pending.
- R10: Odd offsets, offsets 0x00–0x06, 0x1C, 0x1E and 0x28 and above read as 0, and writes to them change nothing.
- R11: Register map (low half / high half): status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, fall 0x20/0x22, rise 0x24/0x26. Bit i of a register belongs to pin i of its half.
- R12: A configuration register reads back the last value written to it. The new value is used starting with the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| bus_wr_i | input | 1 | Write strobe, taken at the clock edge |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request, registered |
| vec_valid_o | output | 1 | `vec_o` names a pending pin |
| vec_o | output | 5 | Lowest pending pin number |

## Verification
The hardest case to reach from the ports is a clear that lands on exactly the edge where a new edge event is detected. That edge is fixed by the synchronizer depth, not by the bus. The stimulus raises the pin, waits two clocks and then issues the clear, so the write meets the edge where the event is detected. It then reads the status back.

Latency and priority between the two halves are checked the same way. Pins are driven at known cycles and read one edge before and one edge after the expected change. A long random phase with slowly changing pins and random register writes, including writes to holes in the map, is compared against a behavioural model on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    K_STAT, K_EN, K_TYPE, K_POL, K_HOLD, K_FALL, K_RISE, K_NONE
  } reg_kind_e;

  // Bit 1 of the offset picks the half; bits 5:2 pick the function.
  function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
    reg_kind_e k;
    if (a[0]) begin
      k = K_NONE;
    end else begin
      case (a[5:2])
        4'h2:    k = K_STAT;
        4'h3:    k = K_EN;
        4'h4:    k = K_TYPE;
        4'h5:    k = K_POL;
        4'h6:    k = K_HOLD;
        4'h8:    k = K_FALL;
        4'h9:    k = K_RISE;
        default: k = K_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  reg_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] stat_q, en_q, type_q, pol_q, hold_q, fall_q, rise_q;
  logic [W-1:0] edge_ev, lvl_ev, ev, clr, stat_d;

  assign clr = (wr_i && kind_i == K_STAT) ? wdata_i : '0;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign edge_ev[b] = (fall_q[b] & prev_i[b] & ~cur_i[b]) |
                          (rise_q[b] & ~prev_i[b] & cur_i[b]);
      assign lvl_ev[b]  = ~(cur_i[b] ^ pol_q[b]);
      assign ev[b]      = type_q[b] ? edge_ev[b] : lvl_ev[b];
      assign stat_d[b]  = hold_q[b] ? (ev[b] | (stat_q[b] & ~clr[b])) : ev[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '0;
      hold_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_i) begin
        case (kind_i)
          K_EN:    en_q   <= wdata_i;
          K_TYPE:  type_q <= wdata_i;
          K_POL:   pol_q  <= wdata_i;
          K_HOLD:  hold_q <= wdata_i;
          K_FALL:  fall_q <= wdata_i;
          K_RISE:  rise_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (kind_i)
      K_STAT:  rd_o = stat_q;
      K_EN:    rd_o = en_q;
      K_TYPE:  rd_o = type_q;
      K_POL:   rd_o = pol_q;
      K_HOLD:  rd_o = hold_q;
      K_FALL:  rd_o = fall_q;
      K_RISE:  rd_o = rise_q;
      default: rd_o = '0;
    endcase
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign hold_o = hold_q;
  assign clr_o  = clr;
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int N     = 32,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int NPIN  = 2 * HALF_W,
  localparam int VEC_W = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  reg_kind_e kind;
  logic      half;
  logic [NPIN-1:0] cur, prev;
  logic [1:0][HALF_W-1:0] stat_w, en_w, hold_w, clr_w, rd_w;
  logic [HALF_W-1:0] stat_lo, stat_hi, en_lo, en_hi, hold_lo, hold_hi, clr_lo, clr_hi;
  logic [NPIN-1:0]  pend;
  logic             any;
  logic [VEC_W-1:0] idx;
  logic             irq_q, vld_q;
  logic [VEC_W-1:0] vec_q;

  assign kind = kind_of(bus_addr_i);
  assign half = bus_addr_i[1];

  gpio_irq_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      gpio_irq_bank #(.W(HALF_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i && (kind != K_NONE) && (half == h[0])),
        .kind_i  (kind),
        .wdata_i (bus_wdata_i),
        .cur_i   (cur[h*HALF_W +: HALF_W]),
        .prev_i  (prev[h*HALF_W +: HALF_W]),
        .stat_o  (stat_w[h]),
        .en_o    (en_w[h]),
        .hold_o  (hold_w[h]),
        .clr_o   (clr_w[h]),
        .rd_o    (rd_w[h])
      );
    end
  endgenerate

  assign stat_lo = stat_w[0];
  assign stat_hi = stat_w[1];
  assign en_lo   = en_w[0];
  assign en_hi   = en_w[1];
  assign hold_lo = hold_w[0];
  assign hold_hi = hold_w[1];
  assign clr_lo  = clr_w[0];
  assign clr_hi  = clr_w[1];

  assign bus_rdata_o = (kind == K_NONE) ? '0 : rd_w[half];

  // Low half sits in the low bits, so a flat lowest-first search gives it priority.
  assign pend = {stat_hi & en_hi, stat_lo & en_lo};

  gpio_irq_prio #(.N(NPIN)) u_prio (.req_i(pend), .any_o(any), .idx_o(idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= any;
      vld_q <= any;
      vec_q <= any ? idx : '0;
    end
  end

  assign irq_o       = irq_q;
  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int HALF_W = 16,
  localparam int VEC_W = $clog2(2 * HALF_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] stat_lo,
  input logic [HALF_W-1:0] stat_hi,
  input logic [HALF_W-1:0] en_lo,
  input logic [HALF_W-1:0] en_hi,
  input logic [HALF_W-1:0] hold_lo,
  input logic [HALF_W-1:0] hold_hi,
  input logic [HALF_W-1:0] clr_lo,
  input logic [HALF_W-1:0] clr_hi,
  input logic              irq_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o
);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|({stat_hi, stat_lo} & {en_hi, en_lo})));

  p_en_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo == '0 && en_hi == '0) |=> !irq_o);

  p_valid_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o == irq_o);

  p_vec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> vec_o == '0);

  p_low_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|(stat_lo & en_lo)) |-> !vec_o[VEC_W-1]);

  p_hold_keep_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_lo & hold_lo & ~clr_lo) & ~stat_lo) == '0);

  p_hold_keep_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_hi & hold_hi & ~clr_hi) & ~stat_hi) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .stat_lo(stat_lo), .stat_hi(stat_hi), .en_lo(en_lo), .en_hi(en_hi),
  .hold_lo(hold_lo), .hold_hi(hold_hi), .clr_lo(clr_lo), .clr_hi(clr_hi),
  .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o, vec_valid_o;
  logic [4:0]  vec_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // Behavioural reference: per-half register arrays indexed 0 (pins 0-15) and 1 (pins 16-31)
  logic [15:0] m_st[2], m_en[2], m_ty[2], m_al[2], m_hd[2], m_fe[2], m_re[2];
  logic [31:0] m_s1, m_s2, m_pv;
  logic        m_irq;
  logic [4:0]  m_vec;

  always @(posedge clk) begin : model
    logic [31:0] pend;
    logic [15:0] clr;
    logic        c, p, ev;
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        m_st[h] = 0; m_en[h] = 0; m_ty[h] = 0; m_al[h] = 0;
        m_hd[h] = 0; m_fe[h] = 0; m_re[h] = 0;
      end
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_irq = 0; m_vec = 0;
    end else begin
      pend = {m_st[1] & m_en[1], m_st[0] & m_en[0]};
      m_irq = (pend != 0);
      m_vec = 0;
      for (int i = 0; i < 32; i++) begin
        if (pend[i]) begin
          m_vec = i[4:0];
          break;
        end
      end
      for (int h = 0; h < 2; h++) begin
        clr = 0;
        if (bus_wr_i && bus_addr_i == (h == 0 ? 6'h08 : 6'h0A)) clr = bus_wdata_i;
        for (int j = 0; j < 16; j++) begin
          c = m_s2[h*16+j];
          p = m_pv[h*16+j];
          if (m_ty[h][j]) ev = (m_fe[h][j] && p && !c) || (m_re[h][j] && !p && c);
          else            ev = (c == m_al[h][j]);
          if (m_hd[h][j]) m_st[h][j] = ev || (m_st[h][j] && !clr[j]);
          else            m_st[h][j] = ev;
        end
      end
      if (bus_wr_i) begin
        case (bus_addr_i)
          6'h0C: m_en[0] = bus_wdata_i;  6'h0E: m_en[1] = bus_wdata_i;
          6'h10: m_ty[0] = bus_wdata_i;  6'h12: m_ty[1] = bus_wdata_i;
          6'h14: m_al[0] = bus_wdata_i;  6'h16: m_al[1] = bus_wdata_i;
          6'h18: m_hd[0] = bus_wdata_i;  6'h1A: m_hd[1] = bus_wdata_i;
          6'h20: m_fe[0] = bus_wdata_i;  6'h22: m_fe[1] = bus_wdata_i;
          6'h24: m_re[0] = bus_wdata_i;  6'h26: m_re[1] = bus_wdata_i;
          default: ;
        endcase
      end
      m_pv = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  function automatic logic [15:0] m_read(input logic [5:0] a);
    case (a)
      6'h08: return m_st[0];  6'h0A: return m_st[1];
      6'h0C: return m_en[0];  6'h0E: return m_en[1];
      6'h10: return m_ty[0];  6'h12: return m_ty[1];
      6'h14: return m_al[0];  6'h16: return m_al[1];
      6'h18: return m_hd[0];  6'h1A: return m_hd[1];
      6'h20: return m_fe[0];  6'h22: return m_fe[1];
      6'h24: return m_re[0];  6'h26: return m_re[1];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    if (a == 6'h08 || a == 6'h0A) return "R5";
    if (m_read(a) === 16'h0 && !(a inside {6'h0C,6'h0E,6'h10,6'h12,6'h14,6'h16,
        6'h18,6'h1A,6'h20,6'h22,6'h24,6'h26})) return "R10";
    return "R12";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare against the model once per clock, at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    n_cyc++;
    chk(tag_of(bus_addr_i), "rdata", 32'(bus_rdata_o), 32'(m_read(bus_addr_i)));
    chk("R8", "irq", 32'(irq_o), 32'(m_irq));
    chk("R9", "vec_valid", 32'(vec_valid_o), 32'(m_irq));
    chk("R9", "vec", 32'(vec_o), 32'(m_vec));
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    cyc();
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    bus_addr_i = a;
    #1;
    chk(tag, $sformatf("read 0x%02h", a), 32'(bus_rdata_o), 32'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    @(negedge clk);
    cycn(2);
    rd(6'h08, 16'h0, "R1"); rd(6'h0E, 16'h0, "R1"); rd(6'h26, 16'h0, "R1");
    chk("R1", "irq in reset", 32'(irq_o), 0);
    chk("R1", "vec in reset", 32'(vec_o), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "irq after release", 32'(irq_o), 0);
    cycn(2);

    // R3: level mode, default polarity is active-low and pins are low
    rd(6'h08, 16'hFFFF, "R3");
    wr(6'h14, 16'hFFFF);
    cyc();
    rd(6'h08, 16'h0000, "R3");

    // R2: synchronizer latency
    pin_i[2] = 1'b1;
    cycn(2);
    rd(6'h08, 16'h0000, "R2");
    cyc();
    rd(6'h08, 16'h0004, "R2");

    // R4/R5: high half, edge mode, rise select on pin 16 with hold
    wr(6'h12, 16'hFFFF);
    wr(6'h26, 16'h0001);
    wr(6'h1A, 16'h0001);
    cyc();
    rd(6'h0A, 16'h0000, "R4");
    pin_i[16] = 1'b1;
    cycn(3);
    rd(6'h0A, 16'h0001, "R4");
    cycn(4);
    rd(6'h0A, 16'h0001, "R5");
    pin_i[16] = 1'b0;
    cycn(4);
    rd(6'h0A, 16'h0001, "R5");

    // R6: write-one-to-clear
    wr(6'h0A, 16'h0000);
    rd(6'h0A, 16'h0001, "R6");
    wr(6'h0A, 16'h0001);
    rd(6'h0A, 16'h0000, "R6");

    // R7: clear meets a new event on the same edge
    pin_i[16] = 1'b1;
    cycn(2);
    wr(6'h0A, 16'h0001);
    rd(6'h0A, 16'h0001, "R7");

    // R5: non-held falling-edge pulse on pin 17
    wr(6'h22, 16'h0002);
    pin_i[17] = 1'b1;
    cycn(5);
    rd(6'h0A, 16'h0001, "R4");
    pin_i[17] = 1'b0;
    cycn(2);
    rd(6'h0A, 16'h0001, "R5");
    cyc();
    rd(6'h0A, 16'h0003, "R5");
    cyc();
    rd(6'h0A, 16'h0001, "R5");

    // R8/R9: enable, priority between halves
    wr(6'h0C, 16'h0004);
    chk("R8", "irq one cycle after enable", 32'(irq_o), 0);
    cyc();
    chk("R8", "irq", 32'(irq_o), 1);
    chk("R9", "vec low", 32'(vec_o), 2);
    wr(6'h0E, 16'h0001);
    cyc();
    chk("R9", "low half wins", 32'(vec_o), 2);
    pin_i[2] = 1'b0;
    cycn(3);
    chk("R9", "vec before status drop", 32'(vec_o), 2);
    cyc();
    chk("R9", "vec high half", 32'(vec_o), 16);
    chk("R9", "valid", 32'(vec_valid_o), 1);
    wr(6'h0E, 16'h0000);
    cyc();
    chk("R8", "irq after disable", 32'(irq_o), 0);
    chk("R9", "vec idle", 32'(vec_o), 0);

    // R10: holes in the map
    wr(6'h1C, 16'hFFFF);
    wr(6'h09, 16'hFFFF);
    wr(6'h28, 16'hFFFF);
    wr(6'h3E, 16'hFFFF);
    wr(6'h0D, 16'hFFFF);
    rd(6'h1C, 16'h0, "R10"); rd(6'h09, 16'h0, "R10"); rd(6'h28, 16'h0, "R10");
    rd(6'h0C, 16'h0004, "R10"); rd(6'h0E, 16'h0000, "R10");

    // R11/R12: readback of configuration
    rd(6'h26, 16'h0001, "R12");
    rd(6'h22, 16'h0002, "R11");
    rd(6'h14, 16'hFFFF, "R11");
    rd(6'h1A, 16'h0001, "R11");
    rd(6'h12, 16'hFFFF, "R11");

    // Random phase compared every clock
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(3) == 0) pin_i[$urandom_range(31)] ^= 1'b1;
      bus_wr_i    = ($urandom_range(3) == 0);
      bus_addr_i  = ($urandom_range(7) == 0) ? 6'($urandom) : {5'($urandom_range(19)), 1'b0};
      bus_wdata_i = 16'($urandom);
      cyc();
    end
    bus_wr_i = 1'b0;
    cycn(4);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule